// File: doc/BRIEF.md
# Timed-Unlock Vector Select Register

This block is a memory-mapped control register. Its main job is to hold one bit that picks where the interrupt vector table lives. Changing that bit on purpose takes two writes in a row:

1. The first write sets a change-enable bit. That opens a short unlock window.
2. A second write inside the window carries the new select value, with the change-enable bit at 0.

Any other attempt to change the select bit is dropped. This guards against a stray store moving the vector table.

While an unlock is in progress, the register raises a suppress signal toward the core. The suppress signal masks interrupts without touching the global interrupt-enable flag. Suppression covers two spans:

- the whole open window;
- after a successful select write, the time until the core reports that the next instruction has retired.

The remaining bits of the register are plain storage. They are written and read back without any unlock rule.

Top module: `vsel_lock_reg`

## Requirements
- R1: After reset, `rd_data` is all zeros, `vsel` is 0 and `irq_suppress` is 0.
- R2: A write with `wr_data[0]` = 1 opens the unlock window. `rd_data[0]` then reads 1 for exactly 4 clock cycles after the write and 0 afterwards, unless a further write intervenes.
- R3: A write with `wr_data[0]` = 0 while the window is open loads `wr_data[1]` into `vsel` and into `rd_data[1]` in the next cycle. That write also closes the window, so `rd_data[0]` reads 0 from the next cycle.
- R4: A write with `wr_data[0]` = 0 while the window is closed leaves `vsel` unchanged.
- R5: A write with `wr_data[0]` = 1 never changes `vsel`, whatever value `wr_data[1]` carries.
- R6: `irq_suppress` is 1 in every cycle in which the window is open. If the window expires without a select write, `irq_suppress` returns to 0 in the same cycle that `rd_data[0]` does.
- R7: After a select write, `irq_suppress` stays 1 until `instr_done` has been sampled high on a later clock edge. It then reads 0 in the next cycle, as long as no new window is open.
- R8: Bits 7 down to 2 are stored from every write and read back unchanged in `rd_data`. The unlock state has no effect on them.
- R9: A write with `wr_data[0]` = 1 while a window is already open restarts the 4-cycle count from that write.
- R10: A select write uses up the window. A second write with `wr_data[0]` = 0 right after it leaves `vsel` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W (8) | Write data. Bit 0 is change-enable, bit 1 is select, the rest are plain storage |
| instr_done | input | 1 | Pulses when the core retires an instruction |
| vsel | output | 1 | Current vector-select value |
| rd_data | output | DATA_W (8) | Readback of the register |
| irq_suppress | output | 1 | Interrupt mask request to the core |

## Verification
The bench builds the register with its default parameters:

- 8-bit data;
- select at bit 1 and change-enable at bit 0;
- a 4-cycle window.

A 3-bit down-counter is therefore enough to reach every step of the window. It also reaches expiry on its last cycle, restarts at each count, and a select write on the final open cycle.

Because the data width is small, random writes set the change-enable bit often enough to reach some cases by chance:

- back-to-back re-arming;
- a commit followed at once by a second select write;
- `instr_done` arriving in the commit cycle itself.

Directed sequences pin down the exact cycles at which the window closes and suppression is released.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

   // Decoded intent of one register write
   typedef struct packed {
      logic arm;      // change-enable written as 1
      logic commit;   // select write accepted inside an open window
   } vsel_wr_cmd_t;

   // Width of a counter able to hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/vsel_unlock_timer.sv
module vsel_unlock_timer #(
   parameter int unsigned WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic commit,
   output logic open
);
   localparam int unsigned CNT_W = vsel_pkg::cnt_width(WINDOW);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (arm)
         cnt_d = LOAD_VAL;
      else if (commit)
         cnt_d = '0;
      else if (cnt_q != '0)
         cnt_d = cnt_q - CNT_W'(1);
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign open = (cnt_q != '0);

endmodule

// File: rtl/vsel_suppress_ctl.sv
module vsel_suppress_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic window_open,
   input  logic commit,
   input  logic instr_done,
   output logic suppress
);
   logic pend_q;
   logic pend_d;

   // A commit has priority: a retire pulse seen with the commit
   // belongs to the committing write itself.
   always_comb begin
      if (commit)
         pend_d = 1'b1;
      else if (instr_done)
         pend_d = 1'b0;
      else
         pend_d = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else
         pend_q <= pend_d;
   end

   assign suppress = window_open | pend_q;

endmodule

// File: rtl/vsel_bits_store.sv
module vsel_bits_store #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SEL_BIT = 1,
   parameter int unsigned EN_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              window_open,
   output logic              sel,
   output logic [DATA_W-1:0] rd_data
);
   logic sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= 1'b0;
      else if (commit)
         sel_q <= wr_data[SEL_BIT];
   end

   assign sel = sel_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == SEL_BIT) begin : g_sel
         assign rd_data[b] = sel_q;
      end else if (b == EN_BIT) begin : g_en
         assign rd_data[b] = window_open;
      end else begin : g_plain
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (wr_en)
               bit_q <= wr_data[b];
         end
         assign rd_data[b] = bit_q;
      end
   end

endmodule

// File: rtl/vsel_lock_reg.sv
module vsel_lock_reg #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SEL_BIT = 1,
   parameter int unsigned EN_BIT  = 0,
   parameter int unsigned WINDOW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              instr_done,
   output logic              vsel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_suppress
);
   import vsel_pkg::*;

   initial begin
      if (DATA_W < 2)        $fatal(1, "DATA_W must be at least 2");
      if (SEL_BIT >= DATA_W) $fatal(1, "SEL_BIT outside register");
      if (EN_BIT >= DATA_W)  $fatal(1, "EN_BIT outside register");
      if (SEL_BIT == EN_BIT) $fatal(1, "SEL_BIT and EN_BIT must differ");
      if (WINDOW < 1)        $fatal(1, "WINDOW must be at least 1");
   end

   vsel_wr_cmd_t cmd;
   logic         win_open;

   always_comb begin
      cmd.arm    = wr_en &  wr_data[EN_BIT];
      cmd.commit = wr_en & ~wr_data[EN_BIT] & win_open;
   end

   vsel_unlock_timer #(
      .WINDOW (WINDOW)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (cmd.arm),
      .commit (cmd.commit),
      .open   (win_open)
   );

   vsel_suppress_ctl u_supp (
      .clk         (clk),
      .rst_n       (rst_n),
      .window_open (win_open),
      .commit      (cmd.commit),
      .instr_done  (instr_done),
      .suppress    (irq_suppress)
   );

   vsel_bits_store #(
      .DATA_W  (DATA_W),
      .SEL_BIT (SEL_BIT),
      .EN_BIT  (EN_BIT)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .commit      (cmd.commit),
      .window_open (win_open),
      .sel         (vsel),
      .rd_data     (rd_data)
   );

endmodule

// File: rtl/vsel_lock_reg_chk.sv
module vsel_lock_reg_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SEL_BIT = 1,
   parameter int unsigned EN_BIT  = 0,
   parameter int unsigned WINDOW  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              vsel,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq_suppress
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 0;
      else if (wr_en && wr_data[EN_BIT])
         run_q <= 1;
      else if (rd_data[EN_BIT])
         run_q <= run_q + 1;
      else
         run_q <= 0;
   end

   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[EN_BIT] |-> (run_q >= 1 && run_q <= WINDOW)); // R2

   AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[EN_BIT]) |=> (rd_data[EN_BIT] && irq_suppress)); // R9

   AST_COMMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[EN_BIT] && rd_data[EN_BIT])
         |=> (vsel == $past(wr_data[SEL_BIT]) && !rd_data[EN_BIT])); // R3

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_data[EN_BIT] && rd_data[EN_BIT]) |=> $stable(vsel)); // R4

   AST_OPEN_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[EN_BIT] |-> irq_suppress); // R6

   AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[SEL_BIT] == vsel); // R3

endmodule

bind vsel_lock_reg vsel_lock_reg_chk #(
   .DATA_W  (DATA_W),
   .SEL_BIT (SEL_BIT),
   .EN_BIT  (EN_BIT),
   .WINDOW  (WINDOW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .vsel         (vsel),
   .rd_data      (rd_data),
   .irq_suppress (irq_suppress)
);

// File: tb/vsel_lock_reg_bench.sv
module vsel_lock_reg_bench;
   localparam int DW  = 8;
   localparam int SB  = 1;
   localparam int EB  = 0;
   localparam int WIN = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          instr_done = 1'b0;
   logic          vsel;
   logic [DW-1:0] rd_data;
   logic          irq_suppress;

   int checks = 0;
   int errors = 0;

   // reference state
   int          m_cnt = 0;
   logic        m_sel = 1'b0;
   logic        m_pend = 1'b0;
   logic [DW-1:0] m_other = '0;

   always #10 clk = ~clk;   // 50 MHz

   vsel_lock_reg u_vsel_lock_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .instr_done   (instr_done),
      .vsel         (vsel),
      .rd_data      (rd_data),
      .irq_suppress (irq_suppress)
   );

   function automatic logic [DW-1:0] plain_mask();
      logic [DW-1:0] m = '1;
      m[SB] = 1'b0;
      m[EB] = 1'b0;
      return m;
   endfunction

   function automatic logic [DW-1:0] exp_rd();
      logic [DW-1:0] r = m_other;
      r[SB] = m_sel;
      r[EB] = (m_cnt != 0);
      return r;
   endfunction

   function automatic logic exp_supp();
      return (m_cnt != 0) || m_pend;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(input logic we, input logic [DW-1:0] d, input logic idone);
      logic arm, commit;
      arm    = we && d[EB];
      commit = we && !d[EB] && (m_cnt != 0);
      if (commit) m_sel = d[SB];
      if (commit) m_pend = 1'b1;
      else if (idone) m_pend = 1'b0;
      if (arm) m_cnt = WIN;
      else if (commit) m_cnt = 0;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (we) m_other = d & plain_mask();
   endtask

   // drive at negedge, apply at posedge, come back to the next negedge
   task automatic cyc(input logic we, input logic [DW-1:0] d, input logic idone);
      wr_en = we;
      wr_data = d;
      instr_done = idone;
      @(posedge clk);
      model_step(we, d, idone);
      @(negedge clk);
      wr_en = 1'b0;
      instr_done = 1'b0;
   endtask

   task automatic compare_all();
      check("R3 vsel", {{(DW-1){1'b0}}, vsel}, {{(DW-1){1'b0}}, m_sel});
      check("R2 window bit", {{(DW-1){1'b0}}, rd_data[EB]}, {{(DW-1){1'b0}}, (m_cnt != 0)});
      check("R6 suppress", {{(DW-1){1'b0}}, irq_suppress}, {{(DW-1){1'b0}}, exp_supp()});
      check("R8 readback", rd_data, exp_rd());
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rd_data", rd_data, '0);
      check("R1 vsel", {7'd0, vsel}, 8'd0);
      check("R1 suppress", {7'd0, irq_suppress}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: select write with window closed ignored
      cyc(1'b1, 8'h02, 1'b0);
      check("R4 vsel", {7'd0, vsel}, 8'd0);

      // R2 / R6: arm and let it expire
      cyc(1'b1, 8'h01, 1'b0);
      for (int i = 0; i < WIN; i++) begin
         check("R2 window open", {7'd0, rd_data[EB]}, 8'd1);
         check("R6 suppress open", {7'd0, irq_suppress}, 8'd1);
         if (i < WIN - 1) cyc(1'b0, 8'h00, 1'b0);
      end
      cyc(1'b0, 8'h00, 1'b0);
      check("R2 window closed", {7'd0, rd_data[EB]}, 8'd0);
      check("R6 suppress released", {7'd0, irq_suppress}, 8'd0);

      // R5: arm with select=1 does not change vsel
      cyc(1'b1, 8'h03, 1'b0);
      check("R5 vsel", {7'd0, vsel}, 8'd0);

      // R9: re-arm on cycle 3 restarts count
      cyc(1'b0, 8'h00, 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      cyc(1'b1, 8'h01, 1'b0);
      for (int i = 0; i < WIN - 1; i++) cyc(1'b0, 8'h00, 1'b0);
      check("R9 still open", {7'd0, rd_data[EB]}, 8'd1);
      // R3: commit on last open cycle
      cyc(1'b1, 8'hA6, 1'b0);
      check("R3 vsel set", {7'd0, vsel}, 8'd1);
      check("R3 window closed", {7'd0, rd_data[EB]}, 8'd0);
      check("R8 plain bits", rd_data & plain_mask(), 8'hA4);
      // R10: second select write ignored
      cyc(1'b1, 8'h00, 1'b0);
      check("R10 vsel kept", {7'd0, vsel}, 8'd1);
      // R7: suppress held until instr_done
      check("R7 pending", {7'd0, irq_suppress}, 8'd1);
      cyc(1'b0, 8'h00, 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      check("R7 still pending", {7'd0, irq_suppress}, 8'd1);
      cyc(1'b0, 8'h00, 1'b1);
      check("R7 released", {7'd0, irq_suppress}, 8'd0);

      // R7: instr_done in the commit cycle does not release
      cyc(1'b1, 8'h01, 1'b0);
      cyc(1'b1, 8'h00, 1'b1);
      check("R7 commit-cycle retire", {7'd0, irq_suppress}, 8'd1);
      check("R3 vsel cleared", {7'd0, vsel}, 8'd0);
      cyc(1'b0, 8'h00, 1'b1);
      compare_all();

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic we;
         logic [DW-1:0] d;
         logic idn;
         we  = ($urandom_range(0, 2) != 0);
         d   = DW'($urandom);
         idn = ($urandom_range(0, 3) == 0);
         cyc(we, d, idn);
         compare_all();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule